// File: doc/BRIEF.md
# Message Trace Capture Unit

This unit sits beside an on-chip message network and copies selected messages into a trace window in memory. Each observed message has a source id, a destination id and a payload. When capture is on, a message is kept if it passes two optional comparisons: one on its destination id and one on its source id. Each comparison has its own enable. A kept message becomes one record on a simple memory write port. The record goes to a pointer that walks from a programmed base toward a programmed limit.

When the pointer reaches the limit, there are two modes. In wrap mode the pointer returns to the base and capture continues. In stop mode capture halts until the unit is configured again. In both modes a sticky flag reports that the limit was reached. The memory port uses a valid/ready pair, but the unit never holds back the network. A record that meets a busy port is dropped and counted. Software programs the unit through a small register write port.

Top module: `msg_trace_capture`

## Requirements
- R1: After reset, `mem_valid`, `limit_hit` and `drop_count` are 0, and capture is off until the control register is written.
- R2: Control register (`cfg_sel`=0) bit 0 turns capture on. With it clear, no message raises `mem_valid`.
- R3: Control bit 2 enables the destination comparison against control bits [15:4]. When it is set, only messages whose `msg_dst` equals that id are captured.
- R4: Control bit 3 enables the source comparison against control bits [27:16]. When it is set, only messages whose `msg_src` equals that id are captured.
- R5: With both comparisons enabled, a message must match both ids. A disabled comparison accepts every id.
- R6: A captured message drives `mem_valid` in the same cycle it is observed. `mem_addr` is the current pointer and `mem_data` is {source, destination, payload}. After each accepted write (`mem_valid` and `mem_ready`) the pointer advances by REC_BYTES. The first record after configuration lands at the base.
- R7: A write to control (`cfg_sel`=0), base (`cfg_sel`=1) or limit (`cfg_sel`=2) reloads the pointer with the base value in force after that write. No message is captured in a cycle with `cfg_we` high.
- R8: In wrap mode (control bit 1 set), an accepted write whose advanced pointer is at or above the limit sends the pointer back to the base and sets `limit_hit`.
- R9: In stop mode (control bit 1 clear), the same event sets `limit_hit`. After it, `mem_valid` stays low until the next reload of R7.
- R10: `limit_hit` stays set until a write with `cfg_sel`=3. That write clears `limit_hit` and `drop_count` and does not move the pointer.
- R11: A captured message that meets `mem_ready` low is dropped. The pointer does not move, and `drop_count` increments, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 limit, 3 clear |
| cfg_wdata | input | ADDR_W | Register write data |
| msg_valid | input | 1 | A message is on the network this cycle |
| msg_src | input | ID_W | Message source id |
| msg_dst | input | ID_W | Message destination id |
| msg_payload | input | PAY_W | Message payload |
| mem_valid | output | 1 | Record write request |
| mem_addr | output | ADDR_W | Record address |
| mem_data | output | 2*ID_W+PAY_W | Record {source, destination, payload} |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| limit_hit | output | 1 | Sticky: the limit has been reached |
| drop_count | output | DROP_W | Saturating count of records lost to a busy port |

## Verification
The hardest situation to reach is the interplay at the end of the window. In stop mode the unit must stay silent after the flag is cleared, and only a configuration write may re-arm it. Drops must not consume window space. To reach this, the bench programs a two-record window in stop mode and fills it. It clears the flag, shows that messages are still ignored, and then rewrites control to restart at the base. A separate sequence holds `mem_ready` low with a narrow counter until the count saturates, and checks that the next accepted record still lands at the address the dropped one would have used.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_CLEAR = 2'd3
  } trace_sel_e;

  localparam int CTL_ON     = 0;
  localparam int CTL_WRAP   = 1;
  localparam int CTL_DST_EN = 2;
  localparam int CTL_SRC_EN = 3;
  localparam int CTL_ID_LSB = 4;
endpackage

// File: rtl/trace_cfg_regs.sv
module trace_cfg_regs
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              on,
  output logic              wrap,
  output logic              dst_en,
  output logic              src_en,
  output logic [ID_W-1:0]   dst_id,
  output logic [ID_W-1:0]   src_id,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] base_next,
  output logic [ADDR_W-1:0] limit_q,
  output logic              reload,
  output logic              clear
);
  localparam int DST_LSB = CTL_ID_LSB;
  localparam int SRC_LSB = CTL_ID_LSB + ID_W;

  logic wr_ctrl, wr_base, wr_limit;

  always_comb begin
    wr_ctrl  = cfg_we && (trace_sel_e'(cfg_sel) == SEL_CTRL);
    wr_base  = cfg_we && (trace_sel_e'(cfg_sel) == SEL_BASE);
    wr_limit = cfg_we && (trace_sel_e'(cfg_sel) == SEL_LIMIT);
    clear    = cfg_we && (trace_sel_e'(cfg_sel) == SEL_CLEAR);
    reload   = wr_ctrl || wr_base || wr_limit;
    base_next = wr_base ? cfg_wdata : base_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on      <= 1'b0;
      wrap    <= 1'b0;
      dst_en  <= 1'b0;
      src_en  <= 1'b0;
      dst_id  <= '0;
      src_id  <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (wr_ctrl) begin
        on     <= cfg_wdata[CTL_ON];
        wrap   <= cfg_wdata[CTL_WRAP];
        dst_en <= cfg_wdata[CTL_DST_EN];
        src_en <= cfg_wdata[CTL_SRC_EN];
        dst_id <= cfg_wdata[DST_LSB +: ID_W];
        src_id <= cfg_wdata[SRC_LSB +: ID_W];
      end
      if (wr_base)  base_q  <= cfg_wdata;
      if (wr_limit) limit_q <= cfg_wdata;
    end
  end

  // R2: the enable bit follows the written control word
  assert_ctrl_on_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (on == $past(cfg_wdata[CTL_ON])));
  // R10: a clear write never touches the window registers
  assert_clear_keeps_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> $stable(base_q) && $stable(limit_q));
endmodule

// File: rtl/trace_filter.sv
module trace_filter #(
  parameter int ID_W = 12
) (
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_src,
  input  logic [ID_W-1:0] msg_dst,
  input  logic            on,
  input  logic            dst_en,
  input  logic            src_en,
  input  logic [ID_W-1:0] dst_id,
  input  logic [ID_W-1:0] src_id,
  output logic            hit
);
  function automatic logic id_ok(input logic en, input logic [ID_W-1:0] want,
                                 input logic [ID_W-1:0] got);
    return !en || (want == got);
  endfunction

  logic dst_ok, src_ok;

  always_comb begin
    dst_ok = id_ok(dst_en, dst_id, msg_dst);
    src_ok = id_ok(src_en, src_id, msg_src);
    hit    = msg_valid && on && dst_ok && src_ok;
  end
endmodule

// File: rtl/trace_ptr.sv
module trace_ptr #(
  parameter int ADDR_W    = 32,
  parameter int REC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [ADDR_W-1:0] base_next,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] limit_q,
  input  logic              wrap,
  input  logic              commit,
  output logic [ADDR_W-1:0] ptr,
  output logic              stopped,
  output logic              reach
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(REC_BYTES);

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p);
    return p + STEP;
  endfunction

  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt   = advance(ptr);
    reach = commit && (nxt >= limit_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      stopped <= 1'b0;
    end else if (reload) begin
      ptr     <= base_next;
      stopped <= 1'b0;
    end else if (commit) begin
      if (reach) begin
        if (wrap) ptr <= base_q;
        else      stopped <= 1'b1;
      end else begin
        ptr <= nxt;
      end
    end
  end

  // R7: a configuration write lands the pointer on the new base
  assert_reload_to_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (ptr == $past(base_next)) && !stopped);
  // R8: wrapping returns to base
  assert_wrap_to_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reach && wrap && !reload) |=> (ptr == $past(base_q)));
  // R9: a stopped window stays stopped until reloaded
  assert_stop_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !reload) |=> stopped);
  // R11: the pointer only moves on reload or accepted write
  assert_ptr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !commit) |=> $stable(ptr));
endmodule

// File: rtl/trace_drop_ctr.sv
module trace_drop_ctr #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bump,
  output logic [DROP_W-1:0] count
);
  localparam logic [DROP_W-1:0] TOP = '1;

  function automatic logic [DROP_W-1:0] sat_inc(input logic [DROP_W-1:0] c);
    return (c == TOP) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= sat_inc(count);
  end

  // R11: saturation holds
  assert_drop_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clear) |=> (count == TOP));
  // R10: clear empties the counter
  assert_drop_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/msg_trace_capture.sv
module msg_trace_capture #(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 12,
  parameter int PAY_W     = 32,
  parameter int REC_BYTES = 8,
  parameter int DROP_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [ADDR_W-1:0]          cfg_wdata,
  input  logic                       msg_valid,
  input  logic [ID_W-1:0]            msg_src,
  input  logic [ID_W-1:0]            msg_dst,
  input  logic [PAY_W-1:0]           msg_payload,
  output logic                       mem_valid,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [2*ID_W+PAY_W-1:0]    mem_data,
  input  logic                       mem_ready,
  output logic                       limit_hit,
  output logic [DROP_W-1:0]          drop_count
);
  logic              on, wrap, dst_en, src_en;
  logic [ID_W-1:0]   dst_id, src_id;
  logic [ADDR_W-1:0] base_q, base_next, limit_q, ptr;
  logic              reload, clear, hit, stopped, reach;
  logic              cand, commit, dropped;

  trace_cfg_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .on(on), .wrap(wrap), .dst_en(dst_en),
    .src_en(src_en), .dst_id(dst_id), .src_id(src_id), .base_q(base_q),
    .base_next(base_next), .limit_q(limit_q), .reload(reload), .clear(clear)
  );

  trace_filter #(.ID_W(ID_W)) u_filter (
    .msg_valid(msg_valid), .msg_src(msg_src), .msg_dst(msg_dst), .on(on),
    .dst_en(dst_en), .src_en(src_en), .dst_id(dst_id), .src_id(src_id),
    .hit(hit)
  );

  always_comb begin
    cand    = hit && !cfg_we && !stopped;
    commit  = cand && mem_ready;
    dropped = cand && !mem_ready;
  end

  trace_ptr #(.ADDR_W(ADDR_W), .REC_BYTES(REC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .reload(reload), .base_next(base_next),
    .base_q(base_q), .limit_q(limit_q), .wrap(wrap), .commit(commit),
    .ptr(ptr), .stopped(stopped), .reach(reach)
  );

  trace_drop_ctr #(.DROP_W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bump(dropped), .count(drop_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     limit_hit <= 1'b0;
    else if (reach) limit_hit <= 1'b1;
    else if (clear) limit_hit <= 1'b0;
  end

  assign mem_valid = cand;
  assign mem_addr  = ptr;
  assign mem_data  = {msg_src, msg_dst, msg_payload};

  // R2: nothing is written while capture is off
  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !mem_valid);
  // R3: destination comparison honoured
  assert_dst_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && dst_en) |-> (msg_dst == dst_id));
  // R4: source comparison honoured
  assert_src_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && src_en) |-> (msg_src == src_id));
  // R7: no capture during a configuration write
  assert_no_write_on_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !mem_valid);
  // R9: no write once the window has stopped
  assert_no_write_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !mem_valid);
  // R10: the flag is sticky until cleared
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_hit && !clear) |=> limit_hit);
  // R8: reaching the limit raises the flag
  assert_flag_on_reach_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> limit_hit);
endmodule

// File: tb/msg_trace_capture_tb.sv
module msg_trace_capture_tb;
  localparam int ADDR_W = 32, ID_W = 12, PAY_W = 32, DROP_W = 3;
  localparam int REC_W = 2*ID_W + PAY_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [ADDR_W-1:0] cfg_wdata = 0;
  logic msg_valid = 0; logic [ID_W-1:0] msg_src = 0, msg_dst = 0;
  logic [PAY_W-1:0] msg_payload = 0; logic mem_ready = 1;
  logic mem_valid; logic [ADDR_W-1:0] mem_addr; logic [REC_W-1:0] mem_data;
  logic limit_hit; logic [DROP_W-1:0] drop_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msg_trace_capture #(.ADDR_W(ADDR_W), .ID_W(ID_W), .PAY_W(PAY_W),
                      .REC_BYTES(8), .DROP_W(DROP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_src(msg_src),
    .msg_dst(msg_dst), .msg_payload(msg_payload), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .limit_hit(limit_hit), .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit on, input bit wr, input bit den,
                                      input bit sen, input logic [11:0] did,
                                      input logic [11:0] sid);
    return {4'b0, sid, did, sen, den, wr, on};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic window(input logic [31:0] b, input logic [31:0] l, input logic [31:0] c);
    wr_reg(2'd1, b); wr_reg(2'd2, l); wr_reg(2'd0, c); wr_reg(2'd3, 0);
  endtask

  task automatic send(input logic [11:0] s, input logic [11:0] d, input logic [31:0] p,
                      input bit rdy, input bit exp_v, input logic [31:0] exp_a,
                      input string req);
    @(negedge clk);
    msg_valid = 1; msg_src = s; msg_dst = d; msg_payload = p; mem_ready = rdy;
    #2;
    chk(mem_valid == exp_v, req, mem_valid, exp_v);
    if (exp_v && mem_valid) begin
      chk(mem_addr == exp_a, req, mem_addr, exp_a);
      chk(mem_data == {s, d, p}, req, mem_data, {s, d, p});
    end
    @(posedge clk); #1;
    msg_valid = 0; mem_ready = 1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(mem_valid == 0, "R1", mem_valid, 0);
    chk(limit_hit == 0, "R1", limit_hit, 0);
    chk(drop_count == 0, "R1", drop_count, 0);
    send(12'h1, 12'h2, 32'h11, 1, 0, 0, "R1");
  endtask

  task automatic t_off;
    window(32'h100, 32'h200, ctl(0, 0, 0, 0, 0, 0));
    send(12'h3, 12'h4, 32'h22, 1, 0, 0, "R2");
  endtask

  task automatic t_basic;
    window(32'h100, 32'h200, ctl(1, 0, 0, 0, 12'h7, 12'h9));
    send(12'h3, 12'h4, 32'hA1, 1, 1, 32'h100, "R6");
    send(12'hABC, 12'h123, 32'hA2, 1, 1, 32'h108, "R5");
    send(12'h0, 12'hFFF, 32'hA3, 1, 1, 32'h110, "R6");
  endtask

  task automatic t_dst;
    window(32'h100, 32'h200, ctl(1, 0, 1, 0, 12'h055, 12'h0));
    send(12'h9, 12'h055, 32'h1, 1, 1, 32'h100, "R3");
    send(12'h9, 12'h056, 32'h2, 1, 0, 0, "R3");
  endtask

  task automatic t_src;
    window(32'h100, 32'h200, ctl(1, 0, 0, 1, 12'h0, 12'h3A0));
    send(12'h3A0, 12'h1, 32'h3, 1, 1, 32'h100, "R4");
    send(12'h3A1, 12'h1, 32'h4, 1, 0, 0, "R4");
  endtask

  task automatic t_both;
    window(32'h100, 32'h200, ctl(1, 0, 1, 1, 12'h020, 12'h010));
    send(12'h010, 12'h020, 32'h5, 1, 1, 32'h100, "R5");
    send(12'h010, 12'h021, 32'h6, 1, 0, 0, "R5");
    send(12'h011, 12'h020, 32'h7, 1, 0, 0, "R5");
  endtask

  task automatic t_reload;
    window(32'h100, 32'h200, ctl(1, 0, 0, 0, 0, 0));
    send(1, 2, 32'h8, 1, 1, 32'h100, "R7");
    send(1, 2, 32'h9, 1, 1, 32'h108, "R7");
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd1; cfg_wdata = 32'h400; msg_valid = 1;
    #2;
    chk(mem_valid == 0, "R7", mem_valid, 0);
    @(negedge clk);
    cfg_we = 0; msg_valid = 0;
    send(1, 2, 32'hA, 1, 1, 32'h400, "R7");
  endtask

  task automatic t_wrap;
    window(32'h100, 32'h120, ctl(1, 1, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      send(1, 2, i, 1, 1, 32'h100 + 8*i, "R8");
      if (i < 3) chk(limit_hit == 0, "R8", limit_hit, 0);
    end
    @(negedge clk);
    chk(limit_hit == 1, "R8", limit_hit, 1);
    send(1, 2, 32'h55, 1, 1, 32'h100, "R8");
    // R10: sticky across cycles, clear keeps pointer
    repeat (3) @(negedge clk);
    chk(limit_hit == 1, "R10", limit_hit, 1);
    wr_reg(2'd3, 0);
    chk(limit_hit == 0, "R10", limit_hit, 0);
    send(1, 2, 32'h56, 1, 1, 32'h108, "R10");
  endtask

  task automatic t_stop;
    window(32'h40, 32'h50, ctl(1, 0, 0, 0, 0, 0));
    send(1, 2, 1, 1, 1, 32'h40, "R9");
    send(1, 2, 2, 1, 1, 32'h48, "R9");
    @(negedge clk);
    chk(limit_hit == 1, "R9", limit_hit, 1);
    send(1, 2, 3, 1, 0, 0, "R9");
    wr_reg(2'd3, 0);
    send(1, 2, 4, 1, 0, 0, "R9");
    wr_reg(2'd0, ctl(1, 0, 0, 0, 0, 0));
    send(1, 2, 5, 1, 1, 32'h40, "R9");
  endtask

  task automatic t_drop;
    window(32'h200, 32'h300, ctl(1, 0, 0, 0, 0, 0));
    send(1, 2, 1, 0, 1, 32'h200, "R11");
    @(negedge clk);
    chk(drop_count == 1, "R11", drop_count, 1);
    send(1, 2, 2, 1, 1, 32'h200, "R11");
    for (int i = 0; i < 8; i++) send(1, 2, 3, 0, 1, 32'h208, "R11");
    @(negedge clk);
    chk(drop_count == 7, "R11", drop_count, 7);
    wr_reg(2'd3, 0);
    chk(drop_count == 0, "R10", drop_count, 0);
    send(1, 2, 4, 1, 1, 32'h208, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_off; t_basic; t_dst; t_src; t_both;
    t_reload; t_wrap; t_stop; t_drop;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule